// File: doc/BRIEF.md
# A/D Converter Interrupt Controller

This block collects the two interrupt causes of an analog-to-digital converter and turns them into a single interrupt request for the CPU. One cause is the completion of a whole group of conversions. The other is an out-of-range reading on any of the monitored channels. The block also forms a vector address from a software-programmed base and a word-select bit that hardware maintains. Software sees two byte-wide registers. The control register holds the two event flags, their enables and a three-bit priority level. The vector register holds the base and the word-select bit.

Each cause latches a flag, and that flag stays set until software writes it back to zero. An enable bit gates each flag into the shared request. Because both causes share one vector block, the word-select bit chooses between two adjacent words. It is refreshed on each interrupt acknowledge, and the watchdog cause is picked ahead of end-of-conversion. While the watchdog is being serviced, end-of-conversion stays pending in its flag. Software can also write 1 to a flag to raise a software interrupt.

Register access uses a plain write strobe, with a combinational read. Event strobes and the acknowledge are single-cycle pulses. None of these interfaces carries data under flow control, so there is no valid/ready handshake and no back-pressure: a write, strobe or acknowledge that is sampled high at a clock edge always takes effect at that edge.

Top module: `adc_irq_unit`

## Requirements
- R1: After reset, the control register reads 0x0F, the vector register reads 0x02 and irq_req is low. reg_addr 0 selects the control register and reg_addr 1 selects the vector register.
- R2: A high eoc_done at a clock edge sets control bit 7 (end-of-conversion flag). The flag stays set until software writes 0 to bit 7.
- R3: A high bit on any lane of ovr_hit at a clock edge sets control bit 6 (watchdog flag). The flag stays set until software writes 0 to bit 6.
- R4: Software writing 1 to bit 7 or bit 6 sets that flag, and the flag then requests an interrupt exactly as a hardware event would.
- R5: irq_req is high exactly when (bit 7 AND bit 5) OR (bit 6 AND bit 4). The output follows register state with no added delay.
- R6: Vector bits 7:2 are a writable base. Bit 1 is the word-select bit and software cannot write it. Bit 0 always reads 0. irq_vector always equals the vector register's read value.
- R7: When irq_ack is high at an edge, word-select becomes 0 if the watchdog flag and its enable are both set. Otherwise it becomes 1 if the end-of-conversion flag and its enable are both set. Otherwise it keeps its value.
- R8: While the watchdog is serviced and cleared, a set end-of-conversion flag stays set. The next acknowledge then selects word 1.
- R9: If eoc_done or ovr_hit sets a flag in the same cycle that software writes 0 to that flag, the flag ends up set.
- R10: Writes to control bit 3 are ignored, and bit 3 always reads 1.
- R11: irq_level always equals control bits 2:0, which are writable and reset to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 control, 1 vector |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| eoc_done | input | 1 | Conversion group finished strobe |
| ovr_hit | input | NUM_MON | Per-channel out-of-bounds strobes |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level |
| irq_vector | output | 8 | Vector address {base, word-select, 0} |

## Verification
Each flag, enable, level and base bit changes at the clock edge that samples its write, strobe or acknowledge. irq_req, irq_level, irq_vector and reg_rdata are combinational from those registers, so every result is due in the cycle right after the causing edge. The bench drives inputs on the falling edge and releases them one falling edge later. It then checks outputs at that same falling edge, which is half a period after the edge where the result became due. The sweeps cover every combination of flags and enables, every priority level and every vector base, with expected values computed from the requirement formulas.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned BASE_W = REG_W - 2;

  // control register bit positions (decoded by software and the arbiter)
  localparam int unsigned B_EOC_F  = 7;
  localparam int unsigned B_OVR_F  = 6;
  localparam int unsigned B_EOC_EN = 5;
  localparam int unsigned B_OVR_EN = 4;
  localparam int unsigned B_RSVD   = 3;

  localparam logic [LVL_W-1:0] LVL_RST = '1;

  typedef enum logic { SEL_CTRL = 1'b0, SEL_VEC = 1'b1 } reg_sel_e;

  typedef struct packed {
    logic             eoc_f;
    logic             ovr_f;
    logic             eoc_en;
    logic             ovr_en;
    logic [LVL_W-1:0] lvl;
  } ctrl_t;
endpackage

// File: rtl/adc_irq_ctrl_reg.sv
module adc_irq_ctrl_reg
  import adc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             eoc_set,
  input  logic             ovr_set,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rdata
);
  ctrl_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.eoc_f  <= 1'b0;
      q.ovr_f  <= 1'b0;
      q.eoc_en <= 1'b0;
      q.ovr_en <= 1'b0;
      q.lvl    <= LVL_RST;
    end else if (wr) begin
      // a hardware set in the same cycle overrides a software clear
      q.eoc_f  <= wdata[B_EOC_F] | eoc_set;
      q.ovr_f  <= wdata[B_OVR_F] | ovr_set;
      q.eoc_en <= wdata[B_EOC_EN];
      q.ovr_en <= wdata[B_OVR_EN];
      q.lvl    <= wdata[LVL_W-1:0];
    end else begin
      q.eoc_f  <= q.eoc_f | eoc_set;
      q.ovr_f  <= q.ovr_f | ovr_set;
    end
  end

  assign ctrl  = q;
  assign rdata = {q.eoc_f, q.ovr_f, q.eoc_en, q.ovr_en, 1'b1, q.lvl};
endmodule

// File: rtl/adc_irq_arbiter.sv
module adc_irq_arbiter
  import adc_irq_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  ws_cur,
  output logic  req,
  output logic  ws_next
);
  logic ovr_act;
  logic eoc_act;

  always_comb begin
    ovr_act = ctrl.ovr_f & ctrl.ovr_en;
    eoc_act = ctrl.eoc_f & ctrl.eoc_en;
    req     = ovr_act | eoc_act;
    // watchdog selects the lower word and wins over end-of-conversion
    if (ovr_act)      ws_next = 1'b0;
    else if (eoc_act) ws_next = 1'b1;
    else              ws_next = ws_cur;
  end
endmodule

// File: rtl/adc_irq_vec_reg.sv
module adc_irq_vec_reg
  import adc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ack,
  input  logic             ws_next,
  output logic             ws,
  output logic [REG_W-1:0] vec
);
  logic [BASE_W-1:0] base_q;
  logic              ws_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr) begin
      base_q <= wdata[REG_W-1:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= 1'b1;
    end else if (ack) begin
      ws_q <= ws_next;
    end
  end

  assign ws  = ws_q;
  assign vec = {base_q, ws_q, 1'b0};
endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit
  import adc_irq_pkg::*;
#(
  parameter int unsigned NUM_MON = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_addr,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               eoc_done,
  input  logic [NUM_MON-1:0] ovr_hit,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [2:0]         irq_level,
  output logic [7:0]         irq_vector
);
  ctrl_t            ctrl;
  logic [REG_W-1:0] ctrl_rd;
  logic [REG_W-1:0] vec_rd;
  logic             ws;
  logic             ws_next;
  logic             wr_ctrl;
  logic             wr_vec;
  logic             ovr_any;

  assign wr_ctrl = reg_wr & (reg_sel_e'(reg_addr) == SEL_CTRL);
  assign wr_vec  = reg_wr & (reg_sel_e'(reg_addr) == SEL_VEC);
  assign ovr_any = |ovr_hit;

  adc_irq_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_ctrl),
    .wdata   (reg_wdata),
    .eoc_set (eoc_done),
    .ovr_set (ovr_any),
    .ctrl    (ctrl),
    .rdata   (ctrl_rd)
  );

  adc_irq_arbiter u_arb (
    .ctrl    (ctrl),
    .ws_cur  (ws),
    .req     (irq_req),
    .ws_next (ws_next)
  );

  adc_irq_vec_reg u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_vec),
    .wdata   (reg_wdata),
    .ack     (irq_ack),
    .ws_next (ws_next),
    .ws      (ws),
    .vec     (vec_rd)
  );

  assign reg_rdata  = (reg_sel_e'(reg_addr) == SEL_VEC) ? vec_rd : ctrl_rd;
  assign irq_level  = ctrl.lvl;
  assign irq_vector = vec_rd;
endmodule

// File: rtl/adc_irq_unit_chk.sv
module adc_irq_unit_chk
  import adc_irq_pkg::*;
#(
  parameter int unsigned NUM_MON = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_addr,
  input logic               reg_wr,
  input logic [7:0]         reg_wdata,
  input logic               eoc_done,
  input logic [NUM_MON-1:0] ovr_hit,
  input logic               irq_ack,
  input logic               irq_req,
  input logic [7:0]         irq_vector,
  input ctrl_t              ctrl
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr & ~reg_addr;

  AST_EOC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_done |=> ctrl.eoc_f); // R2
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovr_hit) |=> ctrl.ovr_f); // R3
  AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[B_EOC_F] && ctrl.eoc_en && reg_wdata[B_EOC_EN]) |=> irq_req); // R4
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctrl.eoc_f && ctrl.eoc_en) && !(ctrl.ovr_f && ctrl.ovr_en)) |-> !irq_req); // R5
  AST_WS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && ctrl.ovr_f && ctrl.ovr_en) |=> !irq_vector[1]); // R7
  AST_EOC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.eoc_f && !ctrl_wr) |=> ctrl.eoc_f); // R8
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_done && ctrl_wr && !reg_wdata[B_EOC_F]) |=> ctrl.eoc_f); // R9
endmodule

bind adc_irq_unit adc_irq_unit_chk #(.NUM_MON(NUM_MON)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .eoc_done   (eoc_done),
  .ovr_hit    (ovr_hit),
  .irq_ack    (irq_ack),
  .irq_req    (irq_req),
  .irq_vector (irq_vector),
  .ctrl       (ctrl)
);

// File: tb/adc_irq_unit_test.sv
module adc_irq_unit_test;
  localparam int NMON = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_addr = 1'b0;
  logic            reg_wr = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic            eoc_done = 1'b0;
  logic [NMON-1:0] ovr_hit = '0;
  logic            irq_ack = 1'b0;
  logic            irq_req;
  logic [2:0]      irq_level;
  logic [7:0]      irq_vector;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic exp_ws = 1'b1;

  always #4 clk = ~clk;

  adc_irq_unit #(.NUM_MON(NMON)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eoc_done(eoc_done),
    .ovr_hit(ovr_hit), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    rd(1'b0, d); check("R1 ctrl reset", d, 8'h0F);
    rd(1'b1, d); check("R1 vec reset", d, 8'h02);
    check("R1 irq_req reset", irq_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep flags, enables, level and reserved bit: R4 R5 R7 R10 R11
    for (int c = 0; c < 128; c++) begin
      logic ef, of_, ee, oe, rb;
      logic [2:0] pl;
      logic [7:0] w;
      logic ereq;
      ef = c[6]; of_ = c[5]; ee = c[4]; oe = c[3];
      pl = c[2:0];
      rb = c[0] ^ c[4];
      w = {ef, of_, ee, oe, rb, pl};
      wr(1'b0, w);
      rd(1'b0, d);
      check("R10 R4 ctrl readback", d, {ef, of_, ee, oe, 1'b1, pl});
      ereq = (ef & ee) | (of_ & oe);
      check("R5 irq_req", irq_req, ereq);
      check("R11 irq_level", irq_level, pl);
      ack();
      if (of_ & oe) exp_ws = 1'b0;
      else if (ef & ee) exp_ws = 1'b1;
      check("R7 word select", irq_vector[1], exp_ws);
    end

    // vector base sweep: R6
    for (int b = 0; b < 64; b++) begin
      logic [7:0] w;
      w = {b[5:0], ~exp_ws, 1'b1};
      wr(1'b1, w);
      rd(1'b1, d);
      check("R6 vec readback", d, {b[5:0], exp_ws, 1'b0});
      check("R6 irq_vector", irq_vector, {b[5:0], exp_ws, 1'b0});
    end

    // hardware end-of-conversion set and hold: R2
    wr(1'b0, 8'h20);
    check("R2 no req before event", irq_req, 0);
    eoc_done = 1'b1; step(); eoc_done = 1'b0;
    rd(1'b0, d); check("R2 eoc flag set", d[7], 1);
    check("R2 req after event", irq_req, 1);
    repeat (5) step();
    rd(1'b0, d); check("R2 eoc flag held", d[7], 1);
    wr(1'b0, 8'h20);
    rd(1'b0, d); check("R2 sw clear", d[7], 0);

    // each monitored channel: R3
    for (int ch = 0; ch < NMON; ch++) begin
      wr(1'b0, 8'h10);
      ovr_hit = '0; ovr_hit[ch] = 1'b1; step(); ovr_hit = '0;
      rd(1'b0, d); check("R3 ovr flag set", d[6], 1);
      check("R3 req", irq_req, 1);
    end
    wr(1'b0, 8'h00);

    // simultaneous events, watchdog first, eoc kept: R7 R8
    wr(1'b0, 8'h30);
    eoc_done = 1'b1; ovr_hit = '1; step(); eoc_done = 1'b0; ovr_hit = '0;
    ack();
    check("R7 watchdog first", irq_vector[1], 0);
    wr(1'b0, 8'hB0);
    rd(1'b0, d); check("R8 eoc still pending", d[7:6], 2'b10);
    check("R8 req remains", irq_req, 1);
    ack();
    check("R8 eoc selected", irq_vector[1], 1);
    wr(1'b0, 8'h30);
    ack();
    check("R7 ws kept when idle", irq_vector[1], 1);

    // hardware set vs software clear same cycle: R9
    wr(1'b0, 8'hF0);
    reg_addr = 1'b0; reg_wdata = 8'h30; reg_wr = 1'b1;
    eoc_done = 1'b1; ovr_hit = 2'b10;
    step();
    reg_wr = 1'b0; eoc_done = 1'b0; ovr_hit = '0;
    rd(1'b0, d); check("R9 hw set wins", d[7:6], 2'b11);

    finish_run();
  end
endmodule